// File: doc/BRIEF.md
# Configuration Command SPI Master

This block is the SPI master that sends fixed-shape configuration commands to a device that can be configured over a slave SPI port. A controller presents one command at a time: an 8-bit opcode, a frame kind, a 24-bit operand and a receive length in bits. The engine drives chip select low and clocks the frame out in SPI mode 0. For read commands it gathers the reply bytes that follow the 32-bit header and returns the first four of them as one word.

Every command starts with a 32-bit header: the opcode, then either a 24-bit argument or zero padding. A raw kind sends a single byte with no header. This lets a bulk stream be pushed byte by byte inside an open chip-select window. A keep flag leaves chip select low when a frame ends. The window closes when a later frame is issued with the flag clear, or when a release request arrives. The SCLK half-period is a parameter given in system clock cycles.

Top module: `spi_cmd_framer`

## Requirements
- R1: SCLK rests low whenever chip select is high. MOSI changes only while SCLK is low, and each frame is sent most significant bit first.
- R2: A read frame (kind 0) carries the opcode, 24 zero bits and then ceil(rx_bits/8) bytes of zeros, so a length of 5 bits clocks one whole byte and a length of 0 clocks none.
- R3: In a read frame, MISO bits sampled during the first 32 clocks are dropped. The following bits fill the returned word from bit 31 downward, one bit per rising edge. Bits of the word beyond the received length read zero, and bytes past the fourth are not kept.
- R4: A no-data frame (kind 1) is the opcode followed by 24 zero bits. No kind other than read alters the returned word.
- R5: An operand frame (kind 2) is the opcode followed by the 24-bit operand, most significant bit first.
- R6: A raw frame (kind 3) clocks exactly the 8 opcode bits and nothing else.
- R7: When keep is set, chip select stays low after the frame and through any further frames. A release request while idle raises it. A frame issued with keep clear ends by raising it.
- R8: A release request made while chip select is already high has no effect: no done pulse and no chip-select edge.
- R9: A command is taken only when the engine is idle. A command presented while busy is ignored and does not change the frame in flight.
- R10: done is a single-cycle pulse. It comes on the cycle chip select rises, or on the cycle of the last falling SCLK edge when chip select is kept low. idle is high during the pulse.
- R11: Every low SCLK phase, including the lead time after chip select falls, lasts HALF_DIV cycles before the rising edge. Chip select rises HALF_DIV cycles after the last falling edge, or HALF_DIV cycles after a release is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Presents a command; accepted when idle |
| cmd_kind | input | 2 | 0 read, 1 no-data, 2 operand, 3 raw byte |
| cmd_opcode | input | 8 | Opcode, or the data byte for raw frames |
| cmd_operand | input | 24 | Operand for kind 2 |
| cmd_rx_bits | input | RX_LEN_W | Receive length in bits for kind 0 |
| cmd_keep_cs | input | 1 | Leave chip select low after this frame |
| cs_release | input | 1 | Raise a held chip select (idle only) |
| idle | output | 1 | Engine can take a command |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_word | output | 32 | Returned read data, first byte in bits 31:24 |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The properties assume that reset is held for at least one clock and that HALF_DIV is at least one. They also assume that MISO moves only after falling SCLK edges or after chip select falls, as a mode 0 slave's does. The bench's slave model advances its MISO pointer only on falling SCLK edges. The bench offers commands only when idle, except for one deliberate command during a busy frame. It pulses a release once with chip select high and once with it held, so that each case the properties cover is actually reached.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int unsigned OPC_BITS  = 8;
    localparam int unsigned ARG_BITS  = 24;
    localparam int unsigned HDR_BITS  = OPC_BITS + ARG_BITS;
    localparam int unsigned WORD_BITS = 32;

    typedef enum logic [1:0] {
        FK_READ  = 2'd0,
        FK_PLAIN = 2'd1,
        FK_ARG   = 2'd2,
        FK_RAW   = 2'd3
    } frame_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } phase_e;

    function automatic int unsigned whole_bytes(int unsigned nbits);
        return (nbits + 7) / 8;
    endfunction

    function automatic int unsigned frame_bits(frame_kind_e kind, int unsigned rx_len_bits);
        int unsigned n;
        case (kind)
            FK_RAW:  n = OPC_BITS;
            FK_READ: n = HDR_BITS + 8 * whole_bytes(rx_len_bits);
            default: n = HDR_BITS;
        endcase
        return n;
    endfunction

    function automatic logic [HDR_BITS-1:0] header_word(frame_kind_e kind,
                                                       logic [OPC_BITS-1:0] opc,
                                                       logic [ARG_BITS-1:0] arg);
        return {opc, (kind == FK_ARG) ? arg : {ARG_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [HDR_BITS-1:0] load_word,
    input  logic                shift,
    output logic                mosi
);
    logic [HDR_BITS-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_word;
        end else if (shift) begin
            sh_q <= {sh_q[HDR_BITS-2:0], 1'b0};
        end
    end

    assign mosi = sh_q[HDR_BITS-1];
endmodule

// File: rtl/spi_rx_pack.sv
module spi_rx_pack
    import spi_cmd_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 sample,
    input  logic [CNT_W-1:0]     bit_idx,
    input  logic                 miso,
    output logic [WORD_BITS-1:0] word
);
    logic [CNT_W-1:0] off;
    logic             in_win;
    logic [4:0]       pos;

    always_comb begin
        off    = bit_idx - CNT_W'(HDR_BITS);
        in_win = (bit_idx >= CNT_W'(HDR_BITS)) && (off < CNT_W'(WORD_BITS));
        pos    = 5'(WORD_BITS - 1) - off[4:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
        end else if (sample && in_win) begin
            word[pos] <= miso;
        end
    end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
    import spi_cmd_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned RX_LEN_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [7:0]          cmd_opcode,
    input  logic [23:0]         cmd_operand,
    input  logic [RX_LEN_W-1:0] cmd_rx_bits,
    input  logic                cmd_keep_cs,
    input  logic                cs_release,
    output logic                idle,
    output logic                done,
    output logic [31:0]         rx_word,
    output logic                spi_sclk,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic                spi_cs_n
);
    localparam int unsigned MAX_RX_BYTES = whole_bytes((1 << RX_LEN_W) - 1);
    localparam int unsigned MAX_BITS     = HDR_BITS + 8 * MAX_RX_BYTES;
    localparam int unsigned CNT_W        = $clog2(MAX_BITS + 1);

    frame_kind_e      kind_in;
    phase_e           st_q;
    logic             cs_n_q, sclk_q, done_q, held_q, is_read_q;
    logic [CNT_W-1:0] bit_q, last_q;
    logic             tick, accept, release_go, at_last;

    assign kind_in    = frame_kind_e'(cmd_kind);
    assign accept     = cmd_valid && (st_q == ST_IDLE);
    assign release_go = cs_release && !cmd_valid && (st_q == ST_IDLE) && held_q;
    assign at_last    = (bit_q == last_q);

    spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (st_q != ST_IDLE),
        .tick (tick)
    );

    spi_tx_shift u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (header_word(kind_in, cmd_opcode, cmd_operand)),
        .shift     ((st_q == ST_HIGH) && tick && !at_last),
        .mosi      (spi_mosi)
    );

    spi_rx_pack #(.CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept && (kind_in == FK_READ)),
        .sample  ((st_q == ST_LOW) && tick && is_read_q),
        .bit_idx (bit_q),
        .miso    (spi_miso),
        .word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cs_n_q    <= 1'b1;
            sclk_q    <= 1'b0;
            done_q    <= 1'b0;
            held_q    <= 1'b0;
            is_read_q <= 1'b0;
            bit_q     <= '0;
            last_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q      <= ST_LOW;
                        cs_n_q    <= 1'b0;
                        bit_q     <= '0;
                        last_q    <= CNT_W'(frame_bits(kind_in, 32'(cmd_rx_bits)) - 1);
                        is_read_q <= (kind_in == FK_READ);
                        held_q    <= cmd_keep_cs;
                    end else if (release_go) begin
                        st_q   <= ST_TAIL;
                        held_q <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        st_q   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        if (!at_last) begin
                            bit_q <= bit_q + 1'b1;
                            st_q  <= ST_LOW;
                        end else if (held_q) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q <= ST_TAIL;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign idle     = (st_q == ST_IDLE);
    assign done     = done_q;
    assign spi_sclk = sclk_q;
    assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk #(
    parameter int unsigned HALF_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic idle,
    input logic done,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n
);
    localparam int unsigned LW = $clog2(HALF_DIV + 1);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || spi_cs_n || spi_sclk) begin
            low_run <= '0;
        end else if (low_run != LW'(HALF_DIV)) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_sclk_rest_r1: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_mosi_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_start_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> $past(cmd_valid && idle));

    p_busy_after_take_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && idle) |=> !idle);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_cs_rise_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> idle);

    p_low_phase_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> (low_run >= LW'(HALF_DIV)));

    p_trail_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (low_run >= LW'(HALF_DIV)));
endmodule

bind spi_cmd_framer spi_cmd_framer_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .idle      (idle),
    .done      (done),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/test_spi_cmd_framer.sv
module test_spi_cmd_framer;
    timeunit 1ns;
    timeprecision 1ps;
    import spi_cmd_pkg::*;

    localparam int unsigned H      = 2;
    localparam int unsigned RXW    = 6;
    localparam int unsigned PERIOD = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmd_valid = 1'b0;
    frame_kind_e    cmd_kind = FK_READ;
    logic [7:0]     cmd_opcode = '0;
    logic [23:0]    cmd_operand = '0;
    logic [RXW-1:0] cmd_rx_bits = '0;
    logic           cmd_keep_cs = 1'b0;
    logic           cs_release = 1'b0;
    logic           idle, done, spi_sclk, spi_mosi, spi_miso, spi_cs_n;
    logic [31:0]    rx_word;

    always #2 clk = ~clk;

    spi_cmd_framer #(.HALF_DIV(H), .RX_LEN_W(RXW)) i_spi_cmd_framer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_opcode(cmd_opcode), .cmd_operand(cmd_operand), .cmd_rx_bits(cmd_rx_bits),
        .cmd_keep_cs(cmd_keep_cs), .cs_release(cs_release), .idle(idle), .done(done),
        .rx_word(rx_word), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int   errors = 0;
    int   checks = 0;
    logic pat  [0:127];
    logic mlog [0:127];
    logic [6:0] sidx = '0;
    int   mcount = 0;
    int   cs_rises = 0;
    int   done_seen = 0;
    longint t_cs_fall = 0, t_cs_rise = 0, t_first_rise = 0, t_last_fall = 0;

    assign spi_miso = pat[sidx];

    always @(posedge spi_sclk) begin
        if (mcount == 0) t_first_rise = $time;
        if (mcount < 128) mlog[mcount] = spi_mosi;
        mcount++;
    end
    always @(negedge spi_sclk) begin
        t_last_fall = $time;
        if (sidx != 7'd127) sidx = sidx + 7'd1;
    end
    always @(negedge spi_cs_n) t_cs_fall = $time;
    always @(posedge spi_cs_n) begin
        t_cs_rise = $time;
        cs_rises++;
    end
    always @(negedge clk) if (done) done_seen++;

    function automatic logic exp_bit(frame_kind_e k, logic [7:0] opc, logic [23:0] arg, int i);
        if (i < 8) return opc[7-i];
        if (k == FK_ARG && i < 32) return arg[31-i];
        return 1'b0;
    endfunction

    function automatic int exp_len(frame_kind_e k, int nbits);
        if (k == FK_RAW) return 8;
        if (k == FK_READ) return 32 + 8 * ((nbits + 7) / 8);
        return 32;
    endfunction

    function automatic logic [31:0] exp_rx(int nbits);
        logic [31:0] w = '0;
        int nb = 8 * ((nbits + 7) / 8);
        for (int j = 0; j < 32; j++) if (j < nb) w[31-j] = pat[32+j];
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_pattern(input bit rnd);
        for (int i = 0; i < 128; i++) pat[i] = rnd ? 1'($urandom % 2) : 1'(((i * 7) >> 2) & 1);
    endtask

    task automatic run_cmd(input frame_kind_e k, input logic [7:0] opc, input logic [23:0] arg,
                           input int nbits, input bit keep, input bit poke, input string req);
        logic [31:0] prev_rx;
        bit          cs_high0;
        int          n, bad, len, mc;
        prev_rx  = rx_word;
        cs_high0 = spi_cs_n;
        sidx   = '0;
        mcount = 0;
        cmd_valid = 1'b1; cmd_kind = k; cmd_opcode = opc; cmd_operand = arg;
        cmd_rx_bits = RXW'(nbits); cmd_keep_cs = keep;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            if (poke && n == 6) begin
                cmd_valid = 1'b1; cmd_kind = FK_RAW; cmd_opcode = 8'h55; cmd_keep_cs = 1'b0;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0;
        chk(n < 5000, req, "frame completes", 64'(n), 64'd5000);
        len = exp_len(k, nbits);
        chk(mcount == len, req, "clock count", 64'(mcount), 64'(len));
        bad = 0;
        for (int i = 0; i < len && i < 128; i++) if (mlog[i] !== exp_bit(k, opc, arg, i)) bad++;
        chk(bad == 0, req, "mosi bit mismatches", 64'(bad), 64'd0);
        if (k == FK_READ)
            chk(rx_word == exp_rx(nbits), "R3", "returned word", 64'(rx_word), 64'(exp_rx(nbits)));
        else
            chk(rx_word == prev_rx, "R4", "word unchanged", 64'(rx_word), 64'(prev_rx));
        chk(spi_cs_n == !keep, "R7", "chip select after frame", 64'(spi_cs_n), 64'(!keep));
        chk(idle == 1'b1, "R10", "idle with done", 64'(idle), 64'd1);
        if (cs_high0)
            chk(t_first_rise - t_cs_fall == H * PERIOD, "R11", "lead time ns",
                64'(t_first_rise - t_cs_fall), 64'(H * PERIOD));
        if (!keep)
            chk(t_cs_rise - t_last_fall == H * PERIOD, "R11", "trail time ns",
                64'(t_cs_rise - t_last_fall), 64'(H * PERIOD));
        mc = mcount;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
        if (poke) begin
            repeat (4 * H + 4) @(negedge clk);
            chk(mcount == mc && idle == 1'b1, "R9", "busy command ignored", 64'(mcount), 64'(mc));
        end
    endtask

    task automatic do_release(input bit held);
        int     d0, r0;
        longint t_req;
        d0 = done_seen;
        r0 = cs_rises;
        t_req = $time;
        cs_release = 1'b1;
        @(negedge clk);
        cs_release = 1'b0;
        repeat (4 * H + 4) @(negedge clk);
        if (held) begin
            chk(spi_cs_n == 1'b1, "R7", "release raises cs", 64'(spi_cs_n), 64'd1);
            chk(done_seen == d0 + 1, "R10", "done on release", 64'(done_seen), 64'(d0 + 1));
            chk(t_cs_rise - (t_req + PERIOD / 2) == H * PERIOD, "R11", "release delay ns",
                64'(t_cs_rise - t_req - PERIOD / 2), 64'(H * PERIOD));
        end else begin
            chk(spi_cs_n == 1'b1 && cs_rises == r0, "R8", "release without hold: cs",
                64'(cs_rises), 64'(r0));
            chk(done_seen == d0, "R8", "release without hold: done", 64'(done_seen), 64'(d0));
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        void'($urandom(32'd4242));
        fill_pattern(1'b0);
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "reset pins", 64'({spi_cs_n, spi_sclk}), 64'h2);
        chk(idle == 1'b1 && done == 1'b0 && rx_word == '0, "R10", "reset status",
            64'({idle, done}), 64'h2);
        rst = 1'b0;
        @(negedge clk);
        cs_rises = 0;

        run_cmd(FK_READ, 8'hE0, 24'h0, 32, 1'b0, 1'b0, "R2");
        fill_pattern(1'b1);
        run_cmd(FK_READ, 8'hF0, 24'h0, 8, 1'b0, 1'b0, "R2");
        run_cmd(FK_READ, 8'h3C, 24'h0, 5, 1'b0, 1'b0, "R2");
        run_cmd(FK_READ, 8'h3C, 24'h0, 0, 1'b0, 1'b0, "R2");
        run_cmd(FK_READ, 8'hA5, 24'h0, 63, 1'b0, 1'b0, "R3");
        run_cmd(FK_PLAIN, 8'hC6, 24'hFFFFFF, 0, 1'b0, 1'b0, "R4");
        run_cmd(FK_ARG, 8'h0E, 24'h010000, 0, 1'b0, 1'b0, "R5");
        run_cmd(FK_RAW, 8'h96, 24'hABCDEF, 0, 1'b0, 1'b0, "R6");
        run_cmd(FK_ARG, 8'h81, 24'h800001, 0, 1'b0, 1'b1, "R9");

        do_release(1'b0);

        run_cmd(FK_PLAIN, 8'h7A, 24'h0, 0, 1'b1, 1'b0, "R7");
        r0 = cs_rises;
        for (int b = 0; b < 3; b++) run_cmd(FK_RAW, 8'(8'h31 * (b + 1)), 24'h0, 0, 1'b1, 1'b0, "R6");
        chk(cs_rises == r0, "R7", "cs held across raw bytes", 64'(cs_rises), 64'(r0));
        do_release(1'b1);

        for (int it = 0; it < 40; it++) begin
            frame_kind_e k = frame_kind_e'($urandom % 4);
            fill_pattern(1'b1);
            run_cmd(k, 8'($urandom), 24'($urandom), int'($urandom % 64), 1'b0, 1'b0,
                    (k == FK_READ) ? "R2" : (k == FK_PLAIN) ? "R4" : (k == FK_ARG) ? "R5" : "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule